// File: doc/BRIEF.md
# Converter Status and Error Flag Register

This block sits at the output of a decimation filter and watches the results it produces. Each time the filter hands over a wide result, the block saturates it to a 24-bit two's complement word, which it places in an output data register. It also records whether the filter overflowed, whether an unread word was overwritten, and whether the analog input stays outside the usable range for several samples in a row. An external flag pin, sampled on the block clock, is folded into the same error summary.

The block tracks whether the filter has settled. Sync events, configuration changes, power-down and a raised external flag all mark the filter as unsettled. A settled event from the filter sequencer marks it settled again. While the filter is unsettled, the sticky error bits are frozen, so that transients from a restarting filter are not reported. All flags are presented as one status word, with the configuration inputs read back in its low bits, and as an active-low error pin. A completed status read clears the sticky bits.

Top module: `conv_status_reg`

## Requirements
- R1: After synchronous reset, status bits 23..18 are all zero, `error_n` is high and `out_data` is zero.
- R2: Status bit 23 (summary error) is the OR of bits 22 (overwrite), 21 (external flag) and 20 (overflow). `error_n` is the inverse of bit 23.
- R3: A `stat_rd_done` pulse clears bits 23, 22, 21, 20 and 18 at the next edge. A clear wins over a set condition in the same cycle.
- R4: Bit 22 sets when a result is loaded while a data read is open. A read opens on `rd_start` and closes on `rd_done`. A load after the read closed leaves bit 22 low.
- R5: While settled, a high `ext_flag` sets bit 21 at the next edge, and it stays set until cleared. One cycle after bit 21 goes high, bit 19 (settled) drops.
- R6: A load with `load_ovf` high, or with a wide value that does not fit in 24 bits, gives 0x7FFFFF for a non-negative wide value and 0x800000 for a negative one. If the block is settled, bit 20 also sets. Loads that fit are passed through unchanged.
- R7: Bit 19 rises one cycle after a `settle_evt` pulse, provided no invalidating condition is present in that cycle.
- R8: Bit 19 drops at the edge after a `sync_evt` pulse or a change of `cfg`. It is held low while `pwr_down` is high and for the first cycle after `pwr_down` falls. A `settle_evt` in any of those cycles is ignored.
- R9: While bit 19 is low, bits 22, 21, 20 and 18 do not change except by a status-read clear. Loads are still saturated and stored.
- R10: Bit 18 (range error) sets when four consecutive settled loads have stored values all above +6,291,455 (0x5FFFFF) or all below −6,291,456 (0xA00000).
- R11: The consecutive out-of-range run restarts on an in-range load and on a change from above range to below range, or the reverse.
- R12: Status bits 17..0 read back `cfg` as registered one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_down | input | 1 | Power-down level |
| sync_evt | input | 1 | Filter sync pulse |
| cfg | input | 18 | Configuration inputs, read back in the status word |
| settle_evt | input | 1 | Settled event from the filter sequencer |
| ext_flag | input | 1 | External flag pin |
| load_vld | input | 1 | Result load strobe |
| load_data | input | 28 | Wide signed filter result |
| load_ovf | input | 1 | Filter overflow indication for this result |
| rd_start | input | 1 | Data read started |
| rd_done | input | 1 | Data read completed |
| stat_rd_done | input | 1 | Status read completed |
| out_data | output | 24 | Saturated output data register |
| status | output | 24 | Status word |
| error_n | output | 1 | Active-low error pin |

## Verification
The bench checks that loads in an unsettled window leave the sticky bits alone while the stored word is still clipped. A design that ignored the freeze would report overflows from a restarting filter. The bench also checks the cycle right after power-down ends, where a design without the extra held cycle would accept a settle event too early. Two range runs are broken partway through, one by a polarity flip and one by an in-range value. A counter that ignored the sign, or never restarted, would raise the range error one sample too soon. A status read that coincides with an overflow load must leave the overflow bit low, so a design where the set wins is caught.

// File: rtl/cvst_pkg.sv
package cvst_pkg;

    // Classification of a stored sample against the usable range
    typedef enum logic [1:0] {
        RC_IN = 2'd0,
        RC_HI = 2'd1,
        RC_LO = 2'd2
    } rng_cls_e;

    // Sticky flag set carried through the status logic
    typedef struct packed {
        logic ovwr;
        logic mflg;
        logic acc;
        logic drng;
    } sticky_t;

    localparam int FLAG_BITS = 6;

    function automatic logic any_error(input sticky_t f);
        return f.ovwr | f.mflg | f.acc;
    endfunction

endpackage

// File: rtl/cvst_clip.sv
module cvst_clip
    import cvst_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int ACC_W    = 28
) (
    input  logic [ACC_W-1:0]    raw,
    input  logic                ovf_in,
    output logic [SAMPLE_W-1:0] clipped,
    output logic                acc_hit,
    output rng_cls_e            cls
);
    localparam int HEAD_W = ACC_W - SAMPLE_W + 1;
    localparam logic signed [SAMPLE_W-1:0] HI_LIM = SAMPLE_W'(3 * (2 ** (SAMPLE_W - 3)) - 1);
    localparam logic signed [SAMPLE_W-1:0] LO_LIM = -SAMPLE_W'(3 * (2 ** (SAMPLE_W - 3)));
    localparam logic [SAMPLE_W-1:0] POS_FS = {1'b0, {(SAMPLE_W-1){1'b1}}};
    localparam logic [SAMPLE_W-1:0] NEG_FS = {1'b1, {(SAMPLE_W-1){1'b0}}};

    logic [HEAD_W-1:0] head;
    logic              fits;

    always_comb begin
        head    = raw[ACC_W-1:SAMPLE_W-1];
        fits    = (&head) | ~(|head);
        acc_hit = ovf_in | ~fits;
        if (acc_hit)
            clipped = raw[ACC_W-1] ? NEG_FS : POS_FS;
        else
            clipped = raw[SAMPLE_W-1:0];
        if ($signed(clipped) > HI_LIM)
            cls = RC_HI;
        else if ($signed(clipped) < LO_LIM)
            cls = RC_LO;
        else
            cls = RC_IN;
    end
endmodule

// File: rtl/cvst_range.sv
module cvst_range
    import cvst_pkg::*;
#(
    parameter int RUN_LEN = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     step,
    input  logic     clear,
    input  rng_cls_e cls,
    output logic     hit
);
    localparam int CNT_W = $clog2(RUN_LEN + 1);
    localparam logic [CNT_W-1:0] RUN_MAX = CNT_W'(RUN_LEN);

    logic [CNT_W-1:0] cnt;
    rng_cls_e         pol;
    logic             extend;
    logic [CNT_W-1:0] cnt_nx;

    always_comb begin
        extend = (cls == pol) && (cnt != '0);
        if (cls == RC_IN)
            cnt_nx = '0;
        else if (extend)
            cnt_nx = (cnt == RUN_MAX) ? RUN_MAX : cnt + 1'b1;
        else
            cnt_nx = CNT_W'(1);
        hit = step && (cls != RC_IN) && (cnt_nx >= RUN_MAX);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
            pol <= RC_IN;
        end else if (step) begin
            cnt <= cnt_nx;
            pol <= cls;
        end
    end

    // R11: an in-range step restarts the run
    a_r11_inrange_restart: assert property (@(posedge clk) disable iff (rst)
        (step && !clear && cls == RC_IN) |=> (cnt == '0));

    // R10: the run length never exceeds its saturation value
    a_r10_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= RUN_MAX);

    // R11: a polarity change starts a run of one
    a_r11_flip_restart: assert property (@(posedge clk) disable iff (rst)
        (step && !clear && cls != RC_IN && pol != RC_IN && cls != pol) |=> (cnt == CNT_W'(1)));
endmodule

// File: rtl/cvst_settle.sv
module cvst_settle #(
    parameter int CFG_W = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwr_down,
    input  logic             sync_evt,
    input  logic [CFG_W-1:0] cfg,
    input  logic             mflg_q,
    input  logic             settle_evt,
    output logic             settled,
    output logic [CFG_W-1:0] cfg_q
);
    logic pd_q;
    logic invalidate;

    always_comb begin
        invalidate = sync_evt | pwr_down | pd_q | (cfg != cfg_q) | mflg_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pd_q    <= 1'b0;
            cfg_q   <= cfg;
            settled <= 1'b0;
        end else begin
            pd_q  <= pwr_down;
            cfg_q <= cfg;
            if (invalidate)
                settled <= 1'b0;
            else if (settle_evt)
                settled <= 1'b1;
        end
    end

    // R8: sync forces the unsettled state
    a_r8_sync_drop: assert property (@(posedge clk) disable iff (rst)
        sync_evt |=> !settled);

    // R8: power-down forces the unsettled state, also one cycle after
    a_r8_pd_drop: assert property (@(posedge clk) disable iff (rst)
        pwr_down |=> ##1 !settled);

    // R7: settling only follows a settle event
    a_r7_rise_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(settled) |-> $past(settle_evt));
endmodule

// File: rtl/conv_status_reg.sv
module conv_status_reg
    import cvst_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int ACC_W    = 28,
    parameter int CFG_W    = 18,
    parameter int RUN_LEN  = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         pwr_down,
    input  logic                         sync_evt,
    input  logic [CFG_W-1:0]             cfg,
    input  logic                         settle_evt,
    input  logic                         ext_flag,
    input  logic                         load_vld,
    input  logic [ACC_W-1:0]             load_data,
    input  logic                         load_ovf,
    input  logic                         rd_start,
    input  logic                         rd_done,
    input  logic                         stat_rd_done,
    output logic [SAMPLE_W-1:0]          out_data,
    output logic [CFG_W+FLAG_BITS-1:0]   status,
    output logic                         error_n
);
    localparam int STATUS_W = CFG_W + FLAG_BITS;
    localparam int B_ERR  = STATUS_W - 1;
    localparam int B_OVWR = STATUS_W - 2;
    localparam int B_MFLG = STATUS_W - 3;
    localparam int B_ACC  = STATUS_W - 4;
    localparam logic [SAMPLE_W-1:0] POS_FS = {1'b0, {(SAMPLE_W-1){1'b1}}};
    localparam logic [SAMPLE_W-1:0] NEG_FS = {1'b1, {(SAMPLE_W-1){1'b0}}};

    logic [SAMPLE_W-1:0] clipped;
    logic                acc_hit;
    rng_cls_e            cls;
    logic                settled;
    logic [CFG_W-1:0]    cfg_q;
    logic                rng_hit;
    logic                rd_open;
    sticky_t             flags;
    sticky_t             flags_nx;
    logic                step;

    cvst_clip #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)) u_clip (
        .raw     (load_data),
        .ovf_in  (load_ovf),
        .clipped (clipped),
        .acc_hit (acc_hit),
        .cls     (cls)
    );

    cvst_settle #(.CFG_W(CFG_W)) u_settle (
        .clk        (clk),
        .rst        (rst),
        .pwr_down   (pwr_down),
        .sync_evt   (sync_evt),
        .cfg        (cfg),
        .mflg_q     (flags.mflg),
        .settle_evt (settle_evt),
        .settled    (settled),
        .cfg_q      (cfg_q)
    );

    assign step = load_vld && settled;

    cvst_range #(.RUN_LEN(RUN_LEN)) u_range (
        .clk   (clk),
        .rst   (rst),
        .step  (step),
        .clear (!settled),
        .cls   (cls),
        .hit   (rng_hit)
    );

    always_comb begin
        flags_nx = flags;
        if (stat_rd_done) begin
            flags_nx = '0;
        end else if (settled) begin
            if (load_vld && rd_open)            flags_nx.ovwr = 1'b1;
            if (ext_flag && !pwr_down)          flags_nx.mflg = 1'b1;
            if (load_vld && acc_hit)            flags_nx.acc  = 1'b1;
            if (rng_hit)                        flags_nx.drng = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags    <= '0;
            rd_open  <= 1'b0;
            out_data <= '0;
        end else begin
            flags <= flags_nx;
            if (rd_start)
                rd_open <= 1'b1;
            else if (rd_done)
                rd_open <= 1'b0;
            if (load_vld)
                out_data <= clipped;
        end
    end

    always_comb begin
        status = {any_error(flags), flags.ovwr, flags.mflg, flags.acc,
                  settled, flags.drng, cfg_q};
        error_n = ~status[B_ERR];
    end

    // R3: a completed status read clears every sticky bit
    a_r3_read_clears: assert property (@(posedge clk) disable iff (rst)
        stat_rd_done |=> (status[B_ERR:B_ACC] == 4'b0) && !status[CFG_W]);

    // R9: frozen sticky bits while unsettled
    a_r9_freeze: assert property (@(posedge clk) disable iff (rst)
        (!status[CFG_W+1] && !stat_rd_done) |=> $stable({status[B_OVWR:B_ACC], status[CFG_W]}));

    // R4: overwrite of an open read is flagged
    a_r4_ovwr_set: assert property (@(posedge clk) disable iff (rst)
        (load_vld && rd_open && settled && !stat_rd_done) |=> status[B_OVWR]);

    // R6: positive saturation
    a_r6_sat_pos: assert property (@(posedge clk) disable iff (rst)
        (load_vld && load_ovf && !load_data[ACC_W-1]) |=> (out_data == POS_FS));

    // R6: negative saturation
    a_r6_sat_neg: assert property (@(posedge clk) disable iff (rst)
        (load_vld && load_ovf && load_data[ACC_W-1]) |=> (out_data == NEG_FS));

    // R5: a raised external-flag bit drops settling one cycle later
    a_r5_flag_unsettles: assert property (@(posedge clk) disable iff (rst)
        $rose(status[B_MFLG]) |=> !status[CFG_W+1]);
endmodule

// File: tb/tb_conv_status_reg.sv
module tb_conv_status_reg;
    localparam int CFG_W = 18;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pwr_down = 1'b0;
    logic        sync_evt = 1'b0;
    logic [17:0] cfg = 18'h2A5C3;
    logic        settle_evt = 1'b0;
    logic        ext_flag = 1'b0;
    logic        load_vld = 1'b0;
    logic [27:0] load_data = '0;
    logic        load_ovf = 1'b0;
    logic        rd_start = 1'b0;
    logic        rd_done = 1'b0;
    logic        stat_rd_done = 1'b0;
    logic [23:0] out_data;
    logic [23:0] status;
    logic        error_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    conv_status_reg dut (
        .clk(clk), .rst(rst), .pwr_down(pwr_down), .sync_evt(sync_evt),
        .cfg(cfg), .settle_evt(settle_evt), .ext_flag(ext_flag),
        .load_vld(load_vld), .load_data(load_data), .load_ovf(load_ovf),
        .rd_start(rd_start), .rd_done(rd_done), .stat_rd_done(stat_rd_done),
        .out_data(out_data), .status(status), .error_n(error_n)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic step1();
        @(negedge clk);
    endtask

    task automatic load(input logic [27:0] d, input logic ovf);
        load_vld = 1'b1; load_data = d; load_ovf = ovf;
        step1();
        load_vld = 1'b0; load_ovf = 1'b0;
    endtask

    task automatic stat_read();
        stat_rd_done = 1'b1; step1(); stat_rd_done = 1'b0;
    endtask

    task automatic settle();
        settle_evt = 1'b1; step1(); settle_evt = 1'b0;
        chk("R7 settled rises", 32'(status[19]), 32'd1);
    endtask

    task automatic t_reset();
        chk("R1 flag bits", 32'(status[23:18]), 32'd0);
        chk("R1 error_n", 32'(error_n), 32'd1);
        chk("R1 out_data", 32'(out_data), 32'd0);
        chk("R12 cfg readback", 32'(status[17:0]), 32'(cfg));
    endtask

    task automatic t_clip();
        settle();
        load(28'h0100000, 1'b1);
        chk("R6 pos sat", 32'(out_data), 32'h7FFFFF);
        chk("R6 acc bit", 32'(status[20]), 32'd1);
        chk("R2 error bit", 32'(status[23]), 32'd1);
        chk("R2 error_n", 32'(error_n), 32'd0);
        load(28'hF000000, 1'b0);
        chk("R6 neg sat no fit", 32'(out_data), 32'h800000);
        load(28'hFFFF123, 1'b0);
        chk("R6 pass through", 32'(out_data), 32'hFFF123);
        stat_read();
        chk("R3 cleared", 32'(status[23:18]), 32'b000010);
        chk("R3 error_n", 32'(error_n), 32'd1);
    endtask

    task automatic t_clear_wins();
        load_vld = 1'b1; load_data = 28'h0000010; load_ovf = 1'b1; stat_rd_done = 1'b1;
        step1();
        load_vld = 1'b0; load_ovf = 1'b0; stat_rd_done = 1'b0;
        chk("R3 clear wins", 32'(status[20]), 32'd0);
    endtask

    task automatic t_ovwr();
        rd_start = 1'b1; step1(); rd_start = 1'b0;
        load(28'h0000123, 1'b0);
        chk("R4 ovwr set", 32'(status[22]), 32'd1);
        chk("R4 data", 32'(out_data), 32'h000123);
        chk("R2 error via ovwr", 32'(error_n), 32'd0);
        stat_read();
        rd_done = 1'b1; step1(); rd_done = 1'b0;
        load(28'h0000456, 1'b0);
        chk("R4 no ovwr after done", 32'(status[22]), 32'd0);
    endtask

    task automatic t_freeze();
        sync_evt = 1'b1; step1(); sync_evt = 1'b0;
        chk("R8 sync drops", 32'(status[19]), 32'd0);
        rd_start = 1'b1; step1(); rd_start = 1'b0;
        load(28'h0200000, 1'b1);
        chk("R9 acc frozen", 32'(status[20]), 32'd0);
        chk("R9 ovwr frozen", 32'(status[22]), 32'd0);
        chk("R9 still clipped", 32'(out_data), 32'h7FFFFF);
        rd_done = 1'b1; step1(); rd_done = 1'b0;
        settle();
    endtask

    task automatic t_mflg();
        ext_flag = 1'b1; step1(); ext_flag = 1'b0;
        chk("R5 mflg set", 32'(status[21]), 32'd1);
        chk("R2 error via mflg", 32'(error_n), 32'd0);
        step1();
        chk("R5 settled drops", 32'(status[19]), 32'd0);
        step1();
        chk("R5 mflg held", 32'(status[21]), 32'd1);
        stat_read();
        chk("R3 mflg cleared", 32'(status[21]), 32'd0);
        chk("R5 still unsettled", 32'(status[19]), 32'd0);
        settle();
    endtask

    task automatic t_cfg();
        cfg = 18'h1337A; step1();
        chk("R12 new cfg", 32'(status[17:0]), 32'h1337A);
        chk("R8 cfg change drops", 32'(status[19]), 32'd0);
        settle();
    endtask

    task automatic t_pd();
        pwr_down = 1'b1; settle_evt = 1'b1; step1(); settle_evt = 1'b0;
        chk("R8 pd drops", 32'(status[19]), 32'd0);
        ext_flag = 1'b1; step1(); ext_flag = 1'b0;
        chk("R9 mflg frozen in pd", 32'(status[21]), 32'd0);
        pwr_down = 1'b0; settle_evt = 1'b1; step1(); settle_evt = 1'b0;
        chk("R8 pd exit cycle", 32'(status[19]), 32'd0);
        settle();
    endtask

    task automatic t_drng();
        load(28'h0000000, 1'b0);
        for (int i = 0; i < 3; i++) load(28'h0600000, 1'b0);
        chk("R10 three high", 32'(status[18]), 32'd0);
        load(28'h0600000, 1'b0);
        chk("R10 four high", 32'(status[18]), 32'd1);
        stat_read();
        load(28'h0000000, 1'b0);
        for (int i = 0; i < 3; i++) load(28'h0600000, 1'b0);
        for (int i = 0; i < 3; i++) load(28'hF9FFFFF, 1'b0);
        chk("R11 flip restarts", 32'(status[18]), 32'd0);
        load(28'hF9FFFFF, 1'b0);
        chk("R10 four low", 32'(status[18]), 32'd1);
        stat_read();
        load(28'h0000000, 1'b0);
        for (int i = 0; i < 2; i++) load(28'h0600000, 1'b0);
        load(28'h05FFFFF, 1'b0);
        for (int i = 0; i < 3; i++) load(28'h0600000, 1'b0);
        chk("R11 in range restarts", 32'(status[18]), 32'd0);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) step1();
        rst = 1'b0;
        step1();
        t_reset();
        t_clip();
        t_clear_wins();
        t_ovwr();
        t_freeze();
        t_mflg();
        t_cfg();
        t_pd();
        t_drng();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule